// File: doc/BRIEF.md
# Dual-Core Level Interrupt Aggregator

This block gathers up to 32 active-high, level-sensitive interrupt lines from devices on a board and presents them to software through a small 32-bit register window. Each line is captured into a raw status word whose bit index equals the line number. Four mask words, one normal-interrupt mask and one machine-check mask for each of two cores, decide which status bits reach four level outputs. Each output is the OR of the status bits its mask lets through.

There is no acknowledge path. An output stays high for as long as an enabled source holds its line high, and falls once the source drops it. The four outputs are evaluated on their own, so a source that is enabled in several masks drives all of the matching outputs at once. A further read-only word returns the number of the highest active source seen by core 0's normal mask. Software uses this word as a quick dispatch hint.

Top module: `irq_aggregator`

## Requirements
- R1: Reading offset 0x00 returns the input lines as sampled one clock earlier, with bit i holding line i.
- R2: Status bits 6 and 17 through 31 always read as zero, whatever level their inputs have.
- R3: A write to offset 0x00 changes nothing: the status and all four masks read back unchanged afterwards.
- R4: The mask words sit at 0x10 (core 0 normal), 0x14 (core 1 normal), 0x18 (core 0 machine-check) and 0x1C (core 1 machine-check). Each holds the 32-bit value last written to it. Read data appears on the cycle after the read strobe.
- R5: After reset all four masks read zero and all four outputs are low.
- R6: Each output equals the OR over bits of (status AND its own mask), registered. A mask bit of 1 enables that source and 0 blocks it.
- R7: The outputs are not arbitrated. A source enabled in more than one mask raises every matching output in the same cycle.
- R8: Outputs are level-driven. An output falls, with no acknowledge, once every enabled source line is low.
- R9: Offset 0x20 reads the index of the highest set bit of (status AND core-0 normal mask). It reads 0x8000_0000 when no such bit is set.
- R10: Reads of any other offset, or of an offset that is not a multiple of 4, return zero. Writes there change no mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_in | input | 32 | Level interrupt lines, active high |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| addr | input | 8 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en and held until the next read |
| irq_out | output | 2 | Normal interrupt request, one per core |
| mchk_out | output | 2 | Machine-check request, one per core |

## Verification
Some properties are checked on every cycle by the assertions. A mask write to an unmapped offset or to the status offset leaves every mask unchanged. An output whose mask was zero, or that saw an all-zero status, stays low. Status reads never show reserved bits. The index word always names a set bit with nothing set above it. Other behaviour can only be shown by the directed scenarios: the exact offset of each mask word, the one-cycle status and output latency, several outputs rising together from one shared source, outputs falling when a line drops with no acknowledge, and the reset values.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  localparam int unsigned OFS_STATUS    = 'h00;
  localparam int unsigned OFS_IRQ_BASE  = 'h10;
  localparam int unsigned OFS_MCHK_BASE = 'h18;
  localparam int unsigned OFS_TOPIDX    = 'h20;
  localparam int unsigned WORD_BYTES    = 4;

  // Slot k: k < n_core is the normal mask of core k, the rest are machine-check masks.
  function automatic int unsigned slot_ofs(input int unsigned k, input int unsigned n_core);
    if (k < n_core) return OFS_IRQ_BASE + WORD_BYTES * k;
    else            return OFS_MCHK_BASE + WORD_BYTES * (k - n_core);
  endfunction

endpackage

// File: rtl/irq_agg_masks.sv
module irq_agg_masks
  import irq_agg_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned N_SLOT = 4,
  parameter int unsigned N_CORE = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [DATA_W-1:0]              wdata,
  output logic [N_SLOT-1:0][DATA_W-1:0]  mask_q
);

  logic [N_SLOT-1:0][DATA_W-1:0] mask_d;
  logic [N_SLOT-1:0]             slot_hit;

  always_comb begin
    for (int k = 0; k < N_SLOT; k++) begin
      slot_hit[k] = wr_en && (addr == ADDR_W'(slot_ofs(k, N_CORE)));
    end
  end

  always_comb begin
    mask_d = mask_q;
    for (int k = 0; k < N_SLOT; k++) begin
      if (slot_hit[k]) mask_d[k] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  // R10 / R3: a write that lands on no mask slot leaves every mask as it was
  assert_unmapped_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr != ADDR_W'(slot_ofs(0, N_CORE))) && (addr != ADDR_W'(slot_ofs(1, N_CORE)))
           && (addr != ADDR_W'(slot_ofs(2, N_CORE))) && (addr != ADDR_W'(slot_ofs(3, N_CORE))))
    |=> (mask_q == $past(mask_q)));

  assert_status_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(OFS_STATUS)) |=> $stable(mask_q));

endmodule

// File: rtl/irq_agg_gate.sv
module irq_agg_gate #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_SLOT = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [DATA_W-1:0]              status,
  input  logic [N_SLOT-1:0][DATA_W-1:0]  mask,
  output logic [N_SLOT-1:0]              out_q
);

  logic [N_SLOT-1:0] out_d;

  for (genvar g = 0; g < N_SLOT; g++) begin : g_out
    always_comb out_d[g] = |(status & mask[g]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_q[g] <= 1'b0;
      else        out_q[g] <= out_d[g];
    end

    // R5 / R6: a blocked-off output never rises
    assert_masked_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mask[g]) == '0) |-> !out_q[g]);
  end

  // R8: with no status bit up, every output is low one cycle later
  assert_level_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(status) == '0) |-> (out_q == '0));

endmodule

// File: rtl/irq_agg_topidx.sv
module irq_agg_topidx #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] active,
  output logic [DATA_W-1:0] word
);

  localparam int unsigned IDX_W = $clog2(DATA_W);

  logic [IDX_W-1:0] idx;
  logic             found;

  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (active[i]) begin
        idx   = IDX_W'(i);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    if (found) word = DATA_W'(idx);
    else       word = {1'b1, {(DATA_W-1){1'b0}}};
  end

  // R9: a reported index points at a set bit and nothing above it is set
  assert_top_index_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !word[DATA_W-1] |-> ((active >> word[IDX_W-1:0]) == DATA_W'(1)));

  assert_none_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    word[DATA_W-1] |-> (active == '0));

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned        DATA_W    = 32,
  parameter int unsigned        ADDR_W    = 8,
  parameter int unsigned        N_CORE    = 2,
  parameter logic [DATA_W-1:0]  LIVE_BITS = 32'h0001_FFBF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] irq_in,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [N_CORE-1:0] irq_out,
  output logic [N_CORE-1:0] mchk_out
);

  localparam int unsigned N_SLOT = 2 * N_CORE;

  // reset: asserted at once, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // status capture
  logic [DATA_W-1:0] status_d, status_q;

  always_comb status_d = irq_in & LIVE_BITS;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) status_q <= '0;
    else            status_q <= status_d;
  end

  // masks
  logic [N_SLOT-1:0][DATA_W-1:0] mask_q;

  irq_agg_masks #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .N_SLOT (N_SLOT),
    .N_CORE (N_CORE)
  ) u_masks (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .mask_q (mask_q)
  );

  // gated outputs
  logic [N_SLOT-1:0] out_q;

  irq_agg_gate #(
    .DATA_W (DATA_W),
    .N_SLOT (N_SLOT)
  ) u_gate (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .status (status_q),
    .mask   (mask_q),
    .out_q  (out_q)
  );

  assign irq_out  = out_q[N_CORE-1:0];
  assign mchk_out = out_q[N_SLOT-1:N_CORE];

  // highest active source for core 0 normal path
  logic [DATA_W-1:0] top_word;

  irq_agg_topidx #(
    .DATA_W (DATA_W)
  ) u_topidx (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .active (status_q & mask_q[0]),
    .word   (top_word)
  );

  // read port
  logic [DATA_W-1:0] rdata_d, rdata_q;
  logic              rdata_en;

  always_comb begin
    rdata_d = '0;
    if (addr == ADDR_W'(OFS_STATUS)) rdata_d = status_q;
    if (addr == ADDR_W'(OFS_TOPIDX)) rdata_d = top_word;
    for (int k = 0; k < N_SLOT; k++) begin
      if (addr == ADDR_W'(slot_ofs(k, N_CORE))) rdata_d = mask_q[k];
    end
  end

  assign rdata_en = rd_en;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)    rdata_q <= '0;
    else if (rdata_en) rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

  // R2: a status read never exposes a reserved position
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    $past(rd_en && addr == ADDR_W'(OFS_STATUS)) |-> ((rdata & ~LIVE_BITS) == '0));

  // R5: right after reset release every output is low
  assert_reset_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_int_n) |-> ((irq_out == '0) && (mchk_out == '0)));

endmodule

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] irq_in;
  logic        wr_en, rd_en;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [1:0]  irq_out, mchk_out;

  int n_checks = 0;
  int n_fail   = 0;

  localparam logic [31:0] LIVE = 32'h0001_FFBF;
  localparam logic [7:0]  MASK_OFS [4] = '{8'h10, 8'h14, 8'h18, 8'h1C};

  logic [31:0] exp_mask [4];

  always #2 clk = ~clk;

  irq_aggregator i_irq_aggregator (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_in   (irq_in),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .irq_out  (irq_out),
    .mchk_out (mchk_out)
  );

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 8'h00; wdata = '0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0; addr = 8'h00;
    d = rdata;
  endtask

  task automatic set_lines(input logic [31:0] v);
    @(negedge clk);
    irq_in = v;
    repeat (2) @(negedge clk);
  endtask

  task automatic write_mask(input int k, input logic [31:0] v);
    bus_write(MASK_OFS[k], v);
    exp_mask[k] = v;
  endtask

  function automatic logic [3:0] model_outs();
    logic [3:0] r;
    for (int k = 0; k < 4; k++) r[k] = |(irq_in & LIVE & exp_mask[k]);
    return r;
  endfunction

  function automatic logic [31:0] model_top();
    logic [31:0] act;
    act = irq_in & LIVE & exp_mask[0];
    if (act == 0) return 32'h8000_0000;
    for (int i = 31; i >= 0; i--) if (act[i]) return 32'(i);
    return 32'h8000_0000;
  endfunction

  task automatic check_outs(input string tag);
    @(negedge clk);
    check32(tag, {28'd0, mchk_out, irq_out}, {28'd0, model_outs()});
  endtask

  task automatic check_all_masks(input string tag);
    logic [31:0] d;
    for (int k = 0; k < 4; k++) begin
      bus_read(MASK_OFS[k], d);
      check32(tag, d, exp_mask[k]);
    end
  endtask

  // R5
  task automatic t_reset();
    logic [31:0] d;
    check32("R5 outputs after reset", {28'd0, mchk_out, irq_out}, 32'd0);
    check_all_masks("R5 mask reset value");
    bus_read(8'h20, d);
    check32("R9 index word after reset", d, 32'h8000_0000);
  endtask

  // R4
  task automatic t_masks();
    write_mask(0, 32'h0000_1234);
    write_mask(1, 32'hA5A5_0001);
    write_mask(2, 32'h0F0F_0F0F);
    write_mask(3, 32'hFFFF_FFFF);
    check_all_masks("R4 mask readback");
    for (int k = 0; k < 4; k++) write_mask(k, 32'h0);
  endtask

  // R1 R2
  task automatic t_status();
    logic [31:0] d;
    logic [31:0] pats [4] = '{32'h0000_0001, 32'h0001_0000, 32'hFFFF_FFFF, 32'h0000_5A3C};
    for (int p = 0; p < 4; p++) begin
      set_lines(pats[p]);
      bus_read(8'h00, d);
      check32("R1 status reflects inputs", d, pats[p] & LIVE);
    end
    set_lines(32'hFFFE_0040);
    bus_read(8'h00, d);
    check32("R2 reserved bits read zero", d, 32'h0);
    set_lines(32'h0);
  endtask

  // R3
  task automatic t_status_ro();
    logic [31:0] d;
    write_mask(1, 32'h0000_00F0);
    set_lines(32'h0000_0300);
    bus_write(8'h00, 32'hFFFF_FFFF);
    bus_read(8'h00, d);
    check32("R3 status unchanged by write", d, 32'h0000_0300);
    check_all_masks("R3 masks unchanged by status write");
    set_lines(32'h0);
    write_mask(1, 32'h0);
  endtask

  // R6
  task automatic t_outputs();
    write_mask(0, 32'h0000_0001);
    write_mask(1, 32'h0000_0002);
    write_mask(2, 32'h0000_0004);
    write_mask(3, 32'h0001_0000);
    set_lines(32'h0000_0001); check_outs("R6 only normal core0");
    set_lines(32'h0000_0006); check_outs("R6 normal core1 and mchk core0");
    set_lines(32'h0001_0000); check_outs("R6 only mchk core1");
    set_lines(32'h0000_FFF8); check_outs("R6 unmasked sources blocked");
    set_lines(32'h0);
    write_mask(0, 32'h0000_0008); check_outs("R6 mask change with lines low");
    set_lines(32'h0000_0008); check_outs("R6 after mask change");
    for (int k = 0; k < 4; k++) write_mask(k, 32'h0);
    check_outs("R6 all masked");
    set_lines(32'h0);
  endtask

  // R7 R8
  task automatic t_shared_level();
    for (int k = 0; k < 4; k++) write_mask(k, 32'h0000_0800);
    set_lines(32'h0000_0800);
    check32("R7 shared source raises all", {28'd0, mchk_out, irq_out}, 32'h0000_000F);
    set_lines(32'h0000_0000);
    check32("R8 outputs fall with line", {28'd0, mchk_out, irq_out}, 32'h0);
    for (int k = 0; k < 4; k++) write_mask(k, 32'h0);
  endtask

  // R9
  task automatic t_topidx();
    logic [31:0] d;
    write_mask(0, 32'h0001_FF7F);
    set_lines(32'h0001_0081); bus_read(8'h20, d); check32("R9 highest is 16", d, model_top());
    set_lines(32'h0000_0005); bus_read(8'h20, d); check32("R9 highest is 2", d, model_top());
    set_lines(32'h0000_0080); bus_read(8'h20, d); check32("R9 masked bit gives none", d, 32'h8000_0000);
    set_lines(32'hFFFE_0040); bus_read(8'h20, d); check32("R9 reserved only gives none", d, 32'h8000_0000);
    set_lines(32'h0000_0001); bus_read(8'h20, d); check32("R9 lowest is 0", d, 32'h0);
    set_lines(32'h0);
    write_mask(0, 32'h0);
  endtask

  // R10
  task automatic t_unmapped();
    logic [31:0] d;
    write_mask(2, 32'h1111_2222);
    bus_write(8'h24, 32'hDEAD_BEEF);
    bus_write(8'h12, 32'hDEAD_BEEF);
    bus_write(8'h08, 32'hDEAD_BEEF);
    check_all_masks("R10 unmapped writes ignored");
    bus_read(8'h24, d); check32("R10 unmapped read 0x24", d, 32'h0);
    bus_read(8'h1A, d); check32("R10 unaligned read 0x1A", d, 32'h0);
    bus_read(8'hFC, d); check32("R10 unmapped read 0xFC", d, 32'h0);
    write_mask(2, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; irq_in = '0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    for (int k = 0; k < 4; k++) exp_mask[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_masks();
    t_status();
    t_status_ro();
    t_outputs();
    t_shared_level();
    t_topidx();
    t_unmapped();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #400000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule